// File: doc/BRIEF.md
# PLL Programming Register Bank

This block holds the byte-wide programming state of a clock-generator PLL behind a simple CPU read/write bus. Six consecutive byte addresses give access to a control byte, a bandwidth byte, the two halves of a feedback multiplier, a VCO range byte and a reference divider. The held values drive the PLL directly as enable, clock-select, prescaler, VCO power, multiplier, range and divider outputs.

The bank also enforces the interlocks between these registers. Automatic bandwidth mode gates the interrupt enable and the status view. The PLL enable and the clock select hold each other in place. A running PLL freezes its own programming. A status flag records every change of the lock input while automatic mode is on. A read of the control byte clears this flag, and the flag together with the interrupt enable raises an interrupt output.

Top module: `pll_cfg_regs`

## Requirements
- R1: The window starts at BASE_ADDR (default 0x36). Offsets 0 to 5 select control, bandwidth, multiplier high, multiplier low, VCO range and reference divider. Reads of any other address return 0x00, and writes to any other address change nothing.
- R2: After reset the bytes read control 0x20, bandwidth 0x00, multiplier high 0x00, multiplier low 0x40, VCO range 0x40 and reference divider 0x01.
- R3: Control bit positions are: 7 interrupt enable, 6 flag (read-only), 5 PLL enable, 4 clock select, 3:2 prescaler, 1:0 VCO power. Bandwidth bits 4:0, multiplier high bits 7:4 and divider bits 7:4 always read 0.
- R4: While automatic mode (bandwidth bit 7) is 0, the interrupt enable reads 0 and ignores writes, the flag and lock bits read 0, and the interrupt output is low.
- R5: While automatic mode is 1, writes to the acquisition bit (bandwidth bit 5) have no effect.
- R6: While the PLL enable is 0 or the VCO range is 0x00, clock select reads 0, drives 0 and ignores writes.
- R7: While clock select is 1, the PLL enable stays 1 and ignores writes.
- R8: While the PLL enable is 1, writes to the multiplier, VCO range and divider bytes have no effect.
- R9: While automatic mode is 1, any change of the lock input sets the flag. A read of the control byte clears it, and a new change in the same cycle wins over the clear. The lock bit (bandwidth bit 6) shows the lock input sampled at the previous clock edge. The interrupt output is flag AND interrupt enable.
- R10: The multiplier output is {high[3:0], low[7:0]}. The range, divider, prescaler, VCO power, enable, clock select, automatic and acquisition outputs follow their fields.
- R11: A write takes effect at one clock edge. Every interlock is judged on the register values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| lock_in | input | 1 | Lock status from the PLL |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 1 | Select PLL as base clock |
| auto_mode | output | 1 | Automatic bandwidth mode |
| acq_mode | output | 1 | Acquisition mode |
| prescale | output | 2 | Prescaler field |
| vco_pwr | output | 2 | VCO power field |
| mult | output | MUL_W | Feedback multiplier |
| vco_range | output | VRS_W | VCO range |
| ref_div | output | RDIV_W | Reference divider |
| pll_irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. In the first, one control write clears the enable and sets clock select together. The stored select bit must stay masked on the outputs and must not hold the enable on afterwards. In the second, a lock change lands in the same cycle as the control read that clears the flag. Directed sequences reach both: they turn the PLL on with a non-zero range, then issue the combined write, and they drive a lock change together with the read. A long pseudo-random phase then mixes writes, reads and lock toggles across and around the window. A behavioural model checks it on every clock.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_REGS = 6;

   // slot order inside the address window (behavioural: fixed offsets)
   typedef enum logic [2:0] {
      SLOT_CTRL = 3'd0,
      SLOT_BW   = 3'd1,
      SLOT_MULH = 3'd2,
      SLOT_MULL = 3'd3,
      SLOT_VRNG = 3'd4,
      SLOT_RDIV = 3'd5
   } slot_e;

   // control byte, MSB first
   typedef struct packed {
      logic       ie;
      logic       flag;
      logic       on;
      logic       bcs;
      logic [1:0] pre;
      logic [1:0] vpr;
   } ctl_byte_t;

   localparam int unsigned BW_AUTO_BIT = 7;
   localparam int unsigned BW_ACQ_BIT  = 5;

endpackage

// File: rtl/pll_cfg_field.sv
module pll_cfg_field #(
   parameter int unsigned W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         frozen,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("pll_cfg_field: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST;
      else if (wr_en && !frozen)
         q <= wdata;
   end

endmodule

// File: rtl/pll_cfg_dec.sv
module pll_cfg_dec
   import pll_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h36
) (
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [NUM_REGS-1:0] wr_hit,
   output logic [NUM_REGS-1:0] rd_hit
);

   if (BASE_ADDR + NUM_REGS > (1 << ADDR_W)) begin : g_bad_base
      $error("pll_cfg_dec: window does not fit the address width");
   end

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + i);
      assign hit[i]    = bus_sel && (bus_addr == SLOT_ADDR);
      assign wr_hit[i] = hit[i] &  bus_wr;
      assign rd_hit[i] = hit[i] & ~bus_wr;
   end

endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
   import pll_cfg_pkg::*;
#(
   parameter bit FLAG_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              wr_bw,
   input  logic              rd_ctl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              lock_in,
   input  logic              vrs_nz,
   output logic [BYTE_W-1:0] ctl_rd,
   output logic [BYTE_W-1:0] bw_rd,
   output logic              pll_on,
   output logic              clk_sel,
   output logic              auto_mode,
   output logic              acq_mode,
   output logic [1:0]        prescale,
   output logic [1:0]        vco_pwr,
   output logic              irq
);

   ctl_byte_t wr_c;
   assign wr_c = ctl_byte_t'(wdata);

   logic       ie_q, flag_q, on_q, bcs_q, auto_q, acq_q, lock_q;
   logic [1:0] pre_q, vpr_q;
   logic       ie_d, flag_d, on_d, bcs_d, auto_d, acq_d;
   logic [1:0] pre_d, vpr_d;

   // visible views, masked by the interlock conditions
   logic ie_vis, flag_vis, lock_vis, bcs_ok, bcs_vis, lock_chg;
   assign ie_vis   = ie_q & auto_q;
   assign flag_vis = flag_q & auto_q;
   assign lock_vis = lock_q & auto_q;
   assign bcs_ok   = on_q & vrs_nz;
   assign bcs_vis  = bcs_q & bcs_ok;
   assign lock_chg = (lock_in ^ lock_q) & auto_q;

   logic unused_bits;
   assign unused_bits = ^{wr_c.flag, wdata[6], wdata[4:0]};

   always_comb begin
      ie_d  = ie_q;
      on_d  = on_q;
      bcs_d = bcs_q;
      pre_d = pre_q;
      vpr_d = vpr_q;
      if (wr_ctl) begin
         ie_d  = wr_c.ie;
         on_d  = wr_c.on;
         bcs_d = wr_c.bcs;
         pre_d = wr_c.pre;
         vpr_d = wr_c.vpr;
      end
      if (!auto_q)  ie_d  = 1'b0;
      if (bcs_vis)  on_d  = 1'b1;
      if (!bcs_ok)  bcs_d = 1'b0;
   end

   always_comb begin
      auto_d = auto_q;
      acq_d  = acq_q;
      if (wr_bw) begin
         auto_d = wdata[BW_AUTO_BIT];
         if (!auto_q) acq_d = wdata[BW_ACQ_BIT];
      end
   end

   if (FLAG_SET_WINS) begin : g_set_wins
      assign flag_d = auto_q & (lock_chg | (flag_q & ~rd_ctl));
   end else begin : g_clr_wins
      assign flag_d = auto_q & ~rd_ctl & (flag_q | lock_chg);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
         on_q   <= 1'b1;
         bcs_q  <= 1'b0;
         pre_q  <= 2'b00;
         vpr_q  <= 2'b00;
         auto_q <= 1'b0;
         acq_q  <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         ie_q   <= ie_d;
         flag_q <= flag_d;
         on_q   <= on_d;
         bcs_q  <= bcs_d;
         pre_q  <= pre_d;
         vpr_q  <= vpr_d;
         auto_q <= auto_d;
         acq_q  <= acq_d;
         lock_q <= lock_in;
      end
   end

   assign ctl_rd    = {ie_vis, flag_vis, on_q, bcs_vis, pre_q, vpr_q};
   assign bw_rd     = {auto_q, lock_vis, acq_q, 5'b00000};
   assign pll_on    = on_q;
   assign clk_sel   = bcs_vis;
   assign auto_mode = auto_q;
   assign acq_mode  = acq_q;
   assign prescale  = pre_q;
   assign vco_pwr   = vpr_q;
   assign irq       = flag_vis & ie_vis;

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
   import pll_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned BASE_ADDR     = 'h36,
   parameter int unsigned MUL_W         = 12,
   parameter int unsigned MUL_RST       = 'h040,
   parameter int unsigned VRS_W         = 8,
   parameter int unsigned VRS_RST       = 'h40,
   parameter int unsigned RDIV_W        = 4,
   parameter int unsigned RDIV_RST      = 'h1,
   parameter bit          FLAG_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              lock_in,
   output logic              pll_en,
   output logic              clk_sel,
   output logic              auto_mode,
   output logic              acq_mode,
   output logic [1:0]        prescale,
   output logic [1:0]        vco_pwr,
   output logic [MUL_W-1:0]  mult,
   output logic [VRS_W-1:0]  vco_range,
   output logic [RDIV_W-1:0] ref_div,
   output logic              pll_irq
);

   localparam int unsigned MULH_W = MUL_W - BYTE_W;
   localparam logic [MUL_W-1:0]  MUL_RST_V  = MUL_W'(MUL_RST);
   localparam logic [VRS_W-1:0]  VRS_RST_V  = VRS_W'(VRS_RST);
   localparam logic [RDIV_W-1:0] RDIV_RST_V = RDIV_W'(RDIV_RST);

   if (MUL_W <= BYTE_W || MUL_W > 2 * BYTE_W) begin : g_bad_mul
      $error("pll_cfg_regs: MUL_W must be 9..16");
   end
   if (VRS_W < 1 || VRS_W > BYTE_W) begin : g_bad_vrs
      $error("pll_cfg_regs: VRS_W must be 1..8");
   end
   if (RDIV_W < 1 || RDIV_W > BYTE_W) begin : g_bad_rdiv
      $error("pll_cfg_regs: RDIV_W must be 1..8");
   end

   logic [NUM_REGS-1:0] wr_hit, rd_hit;

   pll_cfg_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dec_i (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .wr_hit  (wr_hit),
      .rd_hit  (rd_hit)
   );

   logic [MULH_W-1:0] mulh_q;
   logic [BYTE_W-1:0] mull_q;
   logic [VRS_W-1:0]  vrs_q;
   logic [RDIV_W-1:0] rdiv_q;
   logic [BYTE_W-1:0] ctl_rd, bw_rd;

   pll_cfg_ctrl #(.FLAG_SET_WINS(FLAG_SET_WINS)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_hit[int'(SLOT_CTRL)]),
      .wr_bw    (wr_hit[int'(SLOT_BW)]),
      .rd_ctl   (rd_hit[int'(SLOT_CTRL)]),
      .wdata    (bus_wdata),
      .lock_in  (lock_in),
      .vrs_nz   (|vrs_q),
      .ctl_rd   (ctl_rd),
      .bw_rd    (bw_rd),
      .pll_on   (pll_en),
      .clk_sel  (clk_sel),
      .auto_mode(auto_mode),
      .acq_mode (acq_mode),
      .prescale (prescale),
      .vco_pwr  (vco_pwr),
      .irq      (pll_irq)
   );

   pll_cfg_field #(.W(MULH_W), .RST(MUL_RST_V[MUL_W-1:BYTE_W])) mulh_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[int'(SLOT_MULH)]), .frozen(pll_en),
      .wdata(bus_wdata[MULH_W-1:0]), .q(mulh_q)
   );

   pll_cfg_field #(.W(BYTE_W), .RST(MUL_RST_V[BYTE_W-1:0])) mull_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[int'(SLOT_MULL)]), .frozen(pll_en),
      .wdata(bus_wdata), .q(mull_q)
   );

   pll_cfg_field #(.W(VRS_W), .RST(VRS_RST_V)) vrs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[int'(SLOT_VRNG)]), .frozen(pll_en),
      .wdata(bus_wdata[VRS_W-1:0]), .q(vrs_q)
   );

   pll_cfg_field #(.W(RDIV_W), .RST(RDIV_RST_V)) rdiv_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[int'(SLOT_RDIV)]), .frozen(pll_en),
      .wdata(bus_wdata[RDIV_W-1:0]), .q(rdiv_q)
   );

   logic [BYTE_W-1:0] slot_rd [NUM_REGS];
   assign slot_rd[int'(SLOT_CTRL)] = ctl_rd;
   assign slot_rd[int'(SLOT_BW)]   = bw_rd;
   assign slot_rd[int'(SLOT_MULH)] = BYTE_W'(mulh_q);
   assign slot_rd[int'(SLOT_MULL)] = mull_q;
   assign slot_rd[int'(SLOT_VRNG)] = BYTE_W'(vrs_q);
   assign slot_rd[int'(SLOT_RDIV)] = BYTE_W'(rdiv_q);

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_hit[i]) bus_rdata = bus_rdata | slot_rd[i];
   end

   assign mult      = {mulh_q, mull_q};
   assign vco_range = vrs_q;
   assign ref_div   = rdiv_q;

endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h36,
   parameter int unsigned MUL_W     = 12,
   parameter int unsigned VRS_W     = 8,
   parameter int unsigned RDIV_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              pll_en,
   input logic              clk_sel,
   input logic              auto_mode,
   input logic              acq_mode,
   input logic [MUL_W-1:0]  mult,
   input logic [VRS_W-1:0]  vco_range,
   input logic [RDIV_W-1:0] ref_div,
   input logic              pll_irq
);

   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(BASE_ADDR);

   logic rd_any, out_window;
   assign rd_any     = bus_sel && !bus_wr;
   assign out_window = (int'(bus_addr) < int'(BASE_ADDR)) ||
                       (int'(bus_addr) >= int'(BASE_ADDR) + 6);

   // R1
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && out_window) |-> (bus_rdata == 8'h00));

   // R4
   manual_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode |-> !pll_irq);

   // R4
   manual_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && bus_addr == CTL_ADDR && !auto_mode) |-> (bus_rdata[7:6] == 2'b00));

   // R5
   acq_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode |=> (acq_mode == $past(acq_mode)));

   // R6
   sel_needs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_en || vco_range == '0) |-> !clk_sel);

   // R7
   sel_holds_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |=> pll_en);

   // R8
   prog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |=> (mult == $past(mult) && vco_range == $past(vco_range) &&
                  ref_div == $past(ref_div)));

endmodule

bind pll_cfg_regs pll_cfg_chk #(
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MUL_W(MUL_W), .VRS_W(VRS_W), .RDIV_W(RDIV_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .pll_en(pll_en), .clk_sel(clk_sel), .auto_mode(auto_mode),
   .acq_mode(acq_mode), .mult(mult), .vco_range(vco_range), .ref_div(ref_div),
   .pll_irq(pll_irq)
);

// File: tb/pll_cfg_regs_tb.sv
module pll_cfg_regs_tb_top;

   localparam int BASE = 'h36;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       lock_in = 1'b0;
   logic [7:0] bus_rdata;
   logic       pll_en, clk_sel, auto_mode, acq_mode, pll_irq;
   logic [1:0] prescale, vco_pwr;
   logic [11:0] mult;
   logic [7:0] vco_range;
   logic [3:0] ref_div;

   always #5 clk = ~clk;

   pll_cfg_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in), .pll_en(pll_en),
      .clk_sel(clk_sel), .auto_mode(auto_mode), .acq_mode(acq_mode), .prescale(prescale),
      .vco_pwr(vco_pwr), .mult(mult), .vco_range(vco_range), .ref_div(ref_div),
      .pll_irq(pll_irq)
   );

   int    nchk = 0;
   int    nfail = 0;
   string cur_req = "R2";

   // behavioural model of the requirements
   bit m_ie, m_flag, m_on, m_bcs, m_auto, m_acq, m_lk;
   int m_pre, m_vpr, m_mul, m_vrs, m_rdiv;

   function automatic bit sel_vis();
      return m_bcs && m_on && (m_vrs != 0);
   endfunction

   function automatic int exp_read(int a);
      case (a - BASE)
         0: return (int'(m_ie && m_auto) << 7) | (int'(m_flag && m_auto) << 6) |
                   (int'(m_on) << 5) | (int'(sel_vis()) << 4) | (m_pre << 2) | m_vpr;
         1: return (int'(m_auto) << 7) | (int'(m_lk && m_auto) << 6) | (int'(m_acq) << 5);
         2: return (m_mul >> 8) & 'hF;
         3: return m_mul & 'hFF;
         4: return m_vrs;
         5: return m_rdiv;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit wr, rd, o_auto, o_on, ok, vis;
      int off, wd;
      if (!rst_n) begin
         m_ie = 0; m_flag = 0; m_on = 1; m_bcs = 0; m_auto = 0; m_acq = 0; m_lk = 0;
         m_pre = 0; m_vpr = 0; m_mul = 'h040; m_vrs = 'h40; m_rdiv = 1;
      end else begin
         wr = bus_sel && bus_wr;
         rd = bus_sel && !bus_wr;
         off = int'(bus_addr) - BASE;
         wd = int'(bus_wdata);
         o_auto = m_auto;
         o_on = m_on;
         ok = m_on && (m_vrs != 0);
         vis = sel_vis();
         if (wr && off == 0) begin
            m_ie = wd[7]; m_on = wd[5]; m_bcs = wd[4];
            m_pre = (wd >> 2) & 3; m_vpr = wd & 3;
         end
         if (!o_auto) m_ie = 0;
         if (vis) m_on = 1;
         if (!ok) m_bcs = 0;
         if (wr && off == 1) begin
            m_auto = wd[7];
            if (!o_auto) m_acq = wd[5];
         end
         if (o_auto && (lock_in != m_lk)) m_flag = 1;
         else if (rd && off == 0) m_flag = 0;
         if (!o_auto) m_flag = 0;
         m_lk = lock_in;
         if (wr && !o_on) begin
            case (off)
               2: m_mul = (m_mul & 'hFF) | ((wd & 'hF) << 8);
               3: m_mul = (m_mul & 'hF00) | wd;
               4: m_vrs = wd;
               5: m_rdiv = wd & 'hF;
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin : monitor
      int exp_rd;
      #1;
      if (rst_n) begin
         exp_rd = (bus_sel && !bus_wr) ? exp_read(int'(bus_addr)) : 0;
         check(cur_req, "read data", int'(bus_rdata), exp_rd);
         check("R7", "pll_en", int'(pll_en), int'(m_on));
         check("R6", "clk_sel", int'(clk_sel), int'(sel_vis()));
         check("R10", "auto_mode", int'(auto_mode), int'(m_auto));
         check("R5", "acq_mode", int'(acq_mode), int'(m_acq));
         check("R10", "prescale", int'(prescale), m_pre);
         check("R10", "vco_pwr", int'(vco_pwr), m_vpr);
         check("R8", "mult", int'(mult), m_mul);
         check("R8", "vco_range", int'(vco_range), m_vrs);
         check("R8", "ref_div", int'(ref_div), m_rdiv);
         check("R9", "pll_irq", int'(pll_irq), int'(m_flag && m_ie && m_auto));
      end
   end

   task automatic cyc(bit sel, bit wr, int addr, int data, bit lk);
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = 8'(addr); bus_wdata = 8'(data); lock_in = lk;
   endtask

   bit cur_lock = 0;
   task automatic wr8(int addr, int data); cyc(1, 1, addr, data, cur_lock); endtask
   task automatic rd8(int addr);           cyc(1, 0, addr, 0, cur_lock);    endtask
   task automatic idle();                  cyc(0, 0, 0, 0, cur_lock);       endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      finish_up();
   end

   initial begin : stim
      int unsigned seed;
      int r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R2";   // reset values
      for (int a = BASE; a < BASE + 6; a++) rd8(a);

      cur_req = "R1";   // outside the window
      rd8(BASE - 1); rd8(BASE + 6); rd8(0); rd8('hFF);
      wr8(BASE - 1, 'hFF); wr8(BASE + 6, 'hFF);
      rd8(BASE); rd8(BASE + 1);

      cur_req = "R3";   // layout and zero bits
      wr8(BASE, 'h0F); rd8(BASE);
      wr8(BASE + 2, 'hFF); rd8(BASE + 2);
      wr8(BASE + 5, 'hFF); rd8(BASE + 5);
      wr8(BASE + 1, 'h1F); rd8(BASE + 1);

      cur_req = "R4";   // manual mode hides enable and status
      wr8(BASE, 'h80); rd8(BASE);
      cur_lock = 1; idle(); rd8(BASE); rd8(BASE + 1);
      cur_lock = 0; idle();

      cur_req = "R5";   // acquisition bit locked in auto mode
      wr8(BASE + 1, 'hA0); rd8(BASE + 1);
      wr8(BASE + 1, 'h80); rd8(BASE + 1);

      cur_req = "R9";   // flag, read clear, interrupt
      wr8(BASE, 'h80); idle();
      cur_lock = 1; idle(); rd8(BASE); rd8(BASE);
      cur_lock = 0; rd8(BASE);          // change together with clearing read
      rd8(BASE); rd8(BASE + 1);
      cur_lock = 1; idle(); rd8(BASE + 1);
      wr8(BASE + 1, 'h00); rd8(BASE);   // back to manual

      cur_req = "R8";   // programming frozen while enabled
      wr8(BASE, 'h20);
      wr8(BASE + 3, 'h12); wr8(BASE + 2, 'h03); wr8(BASE + 4, 'h00); wr8(BASE + 5, 'h07);
      rd8(BASE + 3); rd8(BASE + 4);

      cur_req = "R10";  // accepted while disabled, outputs follow
      wr8(BASE, 'h00);
      wr8(BASE + 3, 'hA5); wr8(BASE + 2, 'h0C); wr8(BASE + 4, 'h00); wr8(BASE + 5, 'h09);
      rd8(BASE + 2); rd8(BASE + 3); rd8(BASE + 4); rd8(BASE + 5);

      cur_req = "R6";   // select refused with zero range or PLL off
      wr8(BASE, 'h20); wr8(BASE, 'h30); rd8(BASE);
      wr8(BASE, 'h00); wr8(BASE + 4, 'h55);
      wr8(BASE, 'h10); rd8(BASE);
      wr8(BASE, 'h20); wr8(BASE, 'h30); rd8(BASE);

      cur_req = "R7";   // enable pinned by select
      wr8(BASE, 'h00); rd8(BASE);
      wr8(BASE, 'h00); rd8(BASE);

      cur_req = "R11";  // pre-write values decide
      wr8(BASE, 'h20); wr8(BASE, 'h10); rd8(BASE); idle(); rd8(BASE);
      wr8(BASE, 'h20); wr8(BASE + 3, 'h33); rd8(BASE + 3);

      // mixed traffic
      seed = 32'h1234_5678;
      for (int n = 0; n < 1500; n++) begin
         seed = seed * 1103515245 + 12345;
         r = int'(seed >> 8);
         case (r % 5)
            0: idle();
            1, 2: wr8(BASE - 2 + ((r >> 4) % 10), (r >> 12) & 'hFF);
            3: rd8(BASE - 2 + ((r >> 4) % 10));
            default: begin cur_lock = ~cur_lock; idle(); end
         endcase
      end
      idle(); idle();
      finish_up();
   end

endmodule